// File: doc/BRIEF.md
# Trap Entry and Privilege Stack

This block holds the privilege and interrupt-enable history of a hart inside its machine status word. Three (privilege, enable) slots form a small shift stack: a trap shifts every slot one place deeper and starts machine mode with interrupts off. A trap return shifts the slots back and refills the deepest slot with a user-mode entry that has its enable set.

On every trap the block records the cause and the faulting PC. It cancels any held load reservation. One cycle later it issues a redirect whose target is a vector base plus an offset scaled by the privilege that was active when the trap hit. A return redirects to the saved exception PC.

Software writes to the status word pass through a filter that works field by field. An illegal privilege code or an unsupported translation mode leaves that field unchanged. A read-only summary bit reports whether the floating-point or extension state is fully dirty. Trap entry takes precedence over a return, and a return takes precedence over a status write in the same cycle.

Top module: `trap_priv_stack`

## Requirements
- R1: Status layout, as read on `status_q`. Slot i occupies ie at bit 3i and privilege at bits [3i+2:3i+1], with slot 0 being the current one. The modify-privilege bit is bit 9, the float state is [11:10], the extension state is [13:12], the translation mode is [16:14], and the dirty summary is bit XLEN-1. All other bits read 0. Privilege codes are U=00, S=01, M=11.
- R2: Reset state. `status_q` reads 0x96: current privilege M, slots 1 and 2 hold S, and every enable is 0. `redirect_pc` reads VEC_BASE+0x100. `redirect_valid`, `cause_q`, `epc_q` and `resv_valid` read 0.
- R3: A trap request moves slot 1 into slot 2 and slot 0 into slot 1. Slot 0 then becomes M with its enable cleared, and the modify-privilege bit is cleared.
- R4: A return request moves slot 1 into slot 0 and slot 2 into slot 1. Slot 2 becomes U with its enable set to 1.
- R5: In the cycle after a trap, `redirect_valid` is 1 for one cycle and `redirect_pc` equals VEC_BASE + 0x40 × (the privilege code before the trap). After a return, `redirect_pc` equals `epc_q`.
- R6: A trap loads `cause_q` with `trap_cause` and `epc_q` with `trap_pc`.
- R7: A status write updates each privilege field only when the written code is U, S or M. For code 10 the field keeps its old value. Enable bits, the modify-privilege bit and the float and extension state are always written.
- R8: A status write updates the translation mode only when the code is legal for the width. With XLEN 32 the legal codes are bare=0 and 32-bit paging=1. With XLEN 64 they are bare=0, 3-level=2 and 4-level=3. Any other code keeps the old mode.
- R9: The dirty summary bit is 1 exactly when the float state or the extension state equals 11. Writes to it are ignored.
- R10: `resv_set` sets `resv_valid`. A trap clears it, and the trap wins when both arrive in the same cycle.
- R11: In a single cycle, a trap overrides a return and a status write, and a return overrides a status write. The overridden request has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_req | input | 1 | Take a trap this cycle |
| trap_cause | input | XLEN | Cause code of the trap |
| trap_pc | input | XLEN | PC of the faulting instruction |
| ret_req | input | 1 | Return from trap this cycle |
| csr_we | input | 1 | Write the status word |
| csr_wdata | input | XLEN | Status write value |
| resv_set | input | 1 | A load reservation was taken |
| redirect_valid | output | 1 | One-cycle pulse: fetch from redirect_pc |
| redirect_pc | output | XLEN | Redirect target |
| cur_priv | output | 2 | Current privilege |
| cur_ie | output | 1 | Current interrupt enable |
| status_q | output | XLEN | Status word |
| cause_q | output | XLEN | Captured trap cause |
| epc_q | output | XLEN | Captured exception PC |
| resv_valid | output | 1 | Load reservation held |

## Verification
The properties assume that reset is held for at least one clock before any request, and that the request inputs are known (never X) while reset is released. The properties also assume that `trap_pc` and `trap_cause` are stable only within the cycle in which `trap_req` is sampled. The stimulus drives every input on the falling edge and returns each request to 0 after one cycle, so each request is seen at exactly one rising edge. Any overlap of trap, return and write is deliberate and confined to the priority tests.

// File: rtl/trap_stack_pkg.sv
package trap_stack_pkg;

   localparam int STACK_DEPTH = 3;
   localparam int SLOT_BITS   = 3;
   localparam int MPRV_BIT    = 9;
   localparam int FS_LSB      = 10;
   localparam int XS_LSB      = 12;
   localparam int VM_LSB      = 14;
   localparam int VM_W        = 3;
   localparam int USED_BITS   = VM_LSB + VM_W;

   localparam logic [1:0] PRIV_U = 2'b00;
   localparam logic [1:0] PRIV_S = 2'b01;
   localparam logic [1:0] PRIV_M = 2'b11;

   localparam logic [VM_W-1:0] VM_BARE  = 3'd0;
   localparam logic [VM_W-1:0] VM_PG32  = 3'd1;
   localparam logic [VM_W-1:0] VM_PG3L  = 3'd2;
   localparam logic [VM_W-1:0] VM_PG4L  = 3'd3;

   typedef struct packed {
      logic [1:0] prv;
      logic       ie;
   } slot_t;

   function automatic logic priv_legal(input logic [1:0] p);
      return (p == PRIV_U) || (p == PRIV_S) || (p == PRIV_M);
   endfunction

endpackage

// File: rtl/tps_status_filter.sv
module tps_status_filter
   import trap_stack_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic [XLEN-1:0]              wdata,
   input  slot_t [STACK_DEPTH-1:0]      old_stk,
   input  logic [VM_W-1:0]              old_vm,
   output slot_t [STACK_DEPTH-1:0]      new_stk,
   output logic [VM_W-1:0]              new_vm,
   output logic                         new_mprv,
   output logic [1:0]                   new_fs,
   output logic [1:0]                   new_xs
);

   logic [VM_W-1:0] cand_vm;
   logic            vm_ok;
   logic            unused_bits;

   for (genvar i = 0; i < STACK_DEPTH; i++) begin : g_slot
      localparam int LSB = SLOT_BITS * i;
      logic [1:0] cand;
      assign cand           = wdata[LSB+1 +: 2];
      assign new_stk[i].ie  = wdata[LSB];
      assign new_stk[i].prv = priv_legal(cand) ? cand : old_stk[i].prv;
   end

   assign cand_vm = wdata[VM_LSB +: VM_W];

   if (XLEN == 32) begin : g_vm32
      assign vm_ok = (cand_vm == VM_BARE) || (cand_vm == VM_PG32);
   end else begin : g_vm64
      assign vm_ok = (cand_vm == VM_BARE) || (cand_vm == VM_PG3L) ||
                     (cand_vm == VM_PG4L);
   end

   assign new_vm   = vm_ok ? cand_vm : old_vm;
   assign new_mprv = wdata[MPRV_BIT];
   assign new_fs   = wdata[FS_LSB +: 2];
   assign new_xs   = wdata[XS_LSB +: 2];

   assign unused_bits = ^wdata[XLEN-1:USED_BITS];

endmodule

// File: rtl/tps_priv_stack.sv
module tps_priv_stack
   import trap_stack_pkg::*;
(
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    push,
   input  logic                    pop,
   input  logic                    load,
   input  slot_t [STACK_DEPTH-1:0] load_stk,
   input  logic                    load_mprv,
   output slot_t [STACK_DEPTH-1:0] stk,
   output logic                    mprv
);

   for (genvar i = 0; i < STACK_DEPTH; i++) begin : g_lvl
      slot_t q, push_val, pop_val, rst_val;

      if (i == 0) begin : g_top
         assign push_val = '{prv: PRIV_M, ie: 1'b0};
         assign rst_val  = '{prv: PRIV_M, ie: 1'b0};
      end else begin : g_deep
         assign push_val = stk[i-1];
         assign rst_val  = '{prv: PRIV_S, ie: 1'b0};
      end

      if (i == STACK_DEPTH-1) begin : g_fill
         assign pop_val = '{prv: PRIV_U, ie: 1'b1};
      end else begin : g_shift
         assign pop_val = stk[i+1];
      end

      always_ff @(posedge clk) begin
         if (!rst_n)     q <= rst_val;
         else if (push)  q <= push_val;
         else if (pop)   q <= pop_val;
         else if (load)  q <= load_stk[i];
      end

      assign stk[i] = q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     mprv <= 1'b0;
      else if (push)  mprv <= 1'b0;
      else if (load && !pop) mprv <= load_mprv;
   end

endmodule

// File: rtl/tps_trap_unit.sv
module tps_trap_unit #(
   parameter int              XLEN     = 32,
   parameter logic [XLEN-1:0] VEC_BASE = XLEN'('h100)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            take_trap,
   input  logic            take_ret,
   input  logic [XLEN-1:0] trap_cause,
   input  logic [XLEN-1:0] trap_pc,
   input  logic [1:0]      prv_now,
   input  logic            resv_set,
   output logic            redirect_valid,
   output logic [XLEN-1:0] redirect_pc,
   output logic [XLEN-1:0] cause_q,
   output logic [XLEN-1:0] epc_q,
   output logic            resv_valid
);

   localparam int              VEC_SHIFT = 6;
   localparam logic [XLEN-1:0] BOOT_PC   = VEC_BASE + XLEN'('h100);

   logic [XLEN-1:0] vec_target;
   assign vec_target = VEC_BASE + (XLEN'(prv_now) << VEC_SHIFT);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         redirect_valid <= 1'b0;
         redirect_pc    <= BOOT_PC;
         cause_q        <= '0;
         epc_q          <= '0;
      end else begin
         redirect_valid <= take_trap || take_ret;
         if (take_trap) begin
            redirect_pc <= vec_target;
            cause_q     <= trap_cause;
            epc_q       <= trap_pc;
         end else if (take_ret) begin
            redirect_pc <= epc_q;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)         resv_valid <= 1'b0;
      else if (take_trap) resv_valid <= 1'b0;
      else if (resv_set)  resv_valid <= 1'b1;
   end

endmodule

// File: rtl/trap_priv_stack.sv
module trap_priv_stack
   import trap_stack_pkg::*;
#(
   parameter int              XLEN     = 32,
   parameter logic [XLEN-1:0] VEC_BASE = XLEN'('h100)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            trap_req,
   input  logic [XLEN-1:0] trap_cause,
   input  logic [XLEN-1:0] trap_pc,
   input  logic            ret_req,
   input  logic            csr_we,
   input  logic [XLEN-1:0] csr_wdata,
   input  logic            resv_set,
   output logic            redirect_valid,
   output logic [XLEN-1:0] redirect_pc,
   output logic [1:0]      cur_priv,
   output logic            cur_ie,
   output logic [XLEN-1:0] status_q,
   output logic [XLEN-1:0] cause_q,
   output logic [XLEN-1:0] epc_q,
   output logic            resv_valid
);

   if (!(XLEN == 32 || XLEN == 64)) begin : g_bad_xlen
      $error("trap_priv_stack: XLEN must be 32 or 64");
   end
   if (VEC_BASE[7:0] != 8'd0) begin : g_bad_base
      $error("trap_priv_stack: VEC_BASE must be 256-byte aligned");
   end

   logic take_trap, take_ret, take_wr;
   assign take_trap = trap_req;
   assign take_ret  = ret_req && !trap_req;
   assign take_wr   = csr_we && !trap_req && !ret_req;

   slot_t [STACK_DEPTH-1:0] stk, wr_stk;
   logic                    mprv, wr_mprv;
   logic [VM_W-1:0]         vm_q, wr_vm;
   logic [1:0]              fs_q, xs_q, wr_fs, wr_xs;
   logic                    dirty;

   tps_status_filter #(.XLEN(XLEN)) u_filter (
      .wdata    (csr_wdata),
      .old_stk  (stk),
      .old_vm   (vm_q),
      .new_stk  (wr_stk),
      .new_vm   (wr_vm),
      .new_mprv (wr_mprv),
      .new_fs   (wr_fs),
      .new_xs   (wr_xs)
   );

   tps_priv_stack u_stack (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (take_trap),
      .pop       (take_ret),
      .load      (take_wr),
      .load_stk  (wr_stk),
      .load_mprv (wr_mprv),
      .stk       (stk),
      .mprv      (mprv)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vm_q <= VM_BARE;
         fs_q <= 2'b00;
         xs_q <= 2'b00;
      end else if (take_wr) begin
         vm_q <= wr_vm;
         fs_q <= wr_fs;
         xs_q <= wr_xs;
      end
   end

   tps_trap_unit #(.XLEN(XLEN), .VEC_BASE(VEC_BASE)) u_trap (
      .clk            (clk),
      .rst_n          (rst_n),
      .take_trap      (take_trap),
      .take_ret       (take_ret),
      .trap_cause     (trap_cause),
      .trap_pc        (trap_pc),
      .prv_now        (stk[0].prv),
      .resv_set       (resv_set),
      .redirect_valid (redirect_valid),
      .redirect_pc    (redirect_pc),
      .cause_q        (cause_q),
      .epc_q          (epc_q),
      .resv_valid     (resv_valid)
   );

   assign dirty = (fs_q == 2'b11) || (xs_q == 2'b11);

   always_comb begin
      status_q = '0;
      for (int i = 0; i < STACK_DEPTH; i++) begin
         status_q[SLOT_BITS*i]          = stk[i].ie;
         status_q[SLOT_BITS*i+1 +: 2]   = stk[i].prv;
      end
      status_q[MPRV_BIT]       = mprv;
      status_q[FS_LSB +: 2]    = fs_q;
      status_q[XS_LSB +: 2]    = xs_q;
      status_q[VM_LSB +: VM_W] = vm_q;
      status_q[XLEN-1]         = dirty;
   end

   assign cur_priv = stk[0].prv;
   assign cur_ie   = stk[0].ie;

endmodule

// File: rtl/trap_stack_chk.sv
module trap_stack_chk #(
   parameter int              XLEN     = 32,
   parameter logic [XLEN-1:0] VEC_BASE = XLEN'('h100)
) (
   input logic            clk,
   input logic            rst_n,
   input logic            trap_req,
   input logic [XLEN-1:0] trap_cause,
   input logic [XLEN-1:0] trap_pc,
   input logic            ret_req,
   input logic            csr_we,
   input logic            redirect_valid,
   input logic [XLEN-1:0] redirect_pc,
   input logic [1:0]      cur_priv,
   input logic            cur_ie,
   input logic [XLEN-1:0] status_q,
   input logic [XLEN-1:0] cause_q,
   input logic [XLEN-1:0] epc_q,
   input logic            resv_valid
);

   logic [XLEN-1:0] want_vec;
   assign want_vec = VEC_BASE + {{(XLEN-8){1'b0}}, cur_priv, 6'b000000};

   // R3
   a_r3_push: assert property (@(posedge clk) disable iff (!rst_n)
      trap_req |=> (cur_priv == 2'b11) && !cur_ie && !status_q[9] &&
                   (status_q[5:4] == $past(cur_priv)) &&
                   (status_q[3] == $past(cur_ie)));

   // R4
   a_r4_pop: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_req && !trap_req) |=> (cur_priv == $past(status_q[5:4])) &&
                                 (cur_ie == $past(status_q[3])) &&
                                 (status_q[8:6] == 3'b001));

   // R5
   a_r5_vector: assert property (@(posedge clk) disable iff (!rst_n)
      trap_req |=> redirect_valid && (redirect_pc == $past(want_vec)));

   // R6
   a_r6_capture: assert property (@(posedge clk) disable iff (!rst_n)
      trap_req |=> (cause_q == $past(trap_cause)) && (epc_q == $past(trap_pc)));

   // R7
   a_r7_legal_priv: assert property (@(posedge clk) disable iff (!rst_n)
      (status_q[2:1] != 2'b10) && (status_q[5:4] != 2'b10) &&
      (status_q[8:7] != 2'b10));

   // R10
   a_r10_resv_drop: assert property (@(posedge clk) disable iff (!rst_n)
      trap_req |=> !resv_valid);

   // R11
   a_r11_ret_over_wr: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_req && csr_we && !trap_req) |=> (redirect_pc == $past(epc_q)));

endmodule

bind trap_priv_stack trap_stack_chk #(.XLEN(XLEN), .VEC_BASE(VEC_BASE)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .trap_req       (trap_req),
   .trap_cause     (trap_cause),
   .trap_pc        (trap_pc),
   .ret_req        (ret_req),
   .csr_we         (csr_we),
   .redirect_valid (redirect_valid),
   .redirect_pc    (redirect_pc),
   .cur_priv       (cur_priv),
   .cur_ie         (cur_ie),
   .status_q       (status_q),
   .cause_q        (cause_q),
   .epc_q          (epc_q),
   .resv_valid     (resv_valid)
);

// File: tb/trap_priv_stack_test.sv
module trap_priv_stack_test;

   localparam int XLEN = 32;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            trap_req = 1'b0;
   logic [XLEN-1:0] trap_cause = '0;
   logic [XLEN-1:0] trap_pc = '0;
   logic            ret_req = 1'b0;
   logic            csr_we = 1'b0;
   logic [XLEN-1:0] csr_wdata = '0;
   logic            resv_set = 1'b0;
   logic            redirect_valid;
   logic [XLEN-1:0] redirect_pc;
   logic [1:0]      cur_priv;
   logic            cur_ie;
   logic [XLEN-1:0] status_q;
   logic [XLEN-1:0] cause_q;
   logic [XLEN-1:0] epc_q;
   logic            resv_valid;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #10ns clk = ~clk;

   trap_priv_stack #(.XLEN(XLEN), .VEC_BASE(32'h100)) uut (
      .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .trap_cause(trap_cause),
      .trap_pc(trap_pc), .ret_req(ret_req), .csr_we(csr_we),
      .csr_wdata(csr_wdata), .resv_set(resv_set),
      .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
      .cur_priv(cur_priv), .cur_ie(cur_ie), .status_q(status_q),
      .cause_q(cause_q), .epc_q(epc_q), .resv_valid(resv_valid)
   );

   // {write value, expected status after the write}, applied in order from reset
   localparam logic [63:0] WR_TAB [9] = '{
      {32'h0000_0000, 32'h0000_0000},   // R7 all U, legal
      {32'h0000_0004, 32'h0000_0000},   // R7 current priv 10 kept
      {32'h0000_0097, 32'h0000_0097},   // R7 M/S/S with ie
      {32'h0000_0026, 32'h0000_0016},   // R7 slot1 code 10 kept at S
      {32'h0000_0C06, 32'h8000_0C06},   // R9 float state 11 -> dirty
      {32'h0000_5006, 32'h0000_5006},   // R8 32-bit paging legal
      {32'h0000_B006, 32'h8000_7006},   // R8 3-level illegal, R9 ext dirty
      {32'h0000_0344, 32'h0000_0246},   // R7 slots 0 and 2 code 10 kept
      {32'h8000_0006, 32'h0000_0006}    // R9 summary bit not writable
   };

   task automatic check(input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   task automatic report();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   // drive a set of requests for one rising edge; returns at the next falling edge
   task automatic cycle(input logic t, input logic r, input logic w,
                        input logic [XLEN-1:0] wd, input logic [XLEN-1:0] cs,
                        input logic [XLEN-1:0] pc);
      trap_req = t; ret_req = r; csr_we = w;
      csr_wdata = wd; trap_cause = cs; trap_pc = pc;
      @(negedge clk);
      trap_req = 1'b0; ret_req = 1'b0; csr_we = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
   end

   initial begin
      do_reset();
      // R1 R2 reset state
      check("R2", "status", status_q, 32'h96);
      check("R1", "cur_priv", cur_priv, 2'b11);
      check("R2", "redirect_pc", redirect_pc, 32'h200);
      check("R2", "redirect_valid", redirect_valid, 0);
      check("R2", "cause", cause_q, 0);
      check("R2", "epc", epc_q, 0);
      check("R2", "resv", resv_valid, 0);

      foreach (WR_TAB[k]) begin
         cycle(1'b0, 1'b0, 1'b1, WR_TAB[k][63:32], '0, '0);
         check("R7/R8/R9", $sformatf("table write %0d", k), status_q, WR_TAB[k][31:0]);
      end

      do_reset();
      cycle(1'b0, 1'b0, 1'b1, 32'h0000_028B, '0, '0);
      check("R7", "status S/U/S mprv", status_q, 32'h28B);
      resv_set = 1'b1;
      @(negedge clk);
      resv_set = 1'b0;
      check("R10", "resv set", resv_valid, 1);

      // R3 trap from S
      cycle(1'b1, 1'b0, 1'b0, '0, 32'd5, 32'h1234);
      check("R3", "status after trap", status_q, 32'h5E);
      check("R3", "cur_ie", cur_ie, 0);
      check("R5", "vector from S", redirect_pc, 32'h140);
      check("R5", "valid pulse", redirect_valid, 1);
      check("R6", "cause", cause_q, 5);
      check("R6", "epc", epc_q, 32'h1234);
      check("R10", "resv cleared", resv_valid, 0);
      @(negedge clk);
      check("R5", "valid drops", redirect_valid, 0);

      // R3 nested trap from M
      cycle(1'b1, 1'b0, 1'b0, '0, 32'd7, 32'h2000);
      check("R3", "status nested", status_q, 32'hF6);
      check("R5", "vector from M", redirect_pc, 32'h1C0);

      // R4 returns
      cycle(1'b0, 1'b1, 1'b0, '0, '0, '0);
      check("R4", "status pop 1", status_q, 32'h5E);
      check("R5", "ret target", redirect_pc, 32'h2000);
      cycle(1'b0, 1'b1, 1'b0, '0, '0, '0);
      check("R4", "status pop 2", status_q, 32'h4B);
      check("R4", "cur_priv S", cur_priv, 2'b01);

      // R11 trap wins over return and write
      cycle(1'b1, 1'b1, 1'b1, 32'h0, 32'd9, 32'h3000);
      check("R11", "trap wins status", status_q, 32'h5E);
      check("R11", "trap wins target", redirect_pc, 32'h140);
      check("R11", "trap wins epc", epc_q, 32'h3000);

      // R11 return wins over write
      cycle(1'b0, 1'b1, 1'b1, 32'h0000_0C00, '0, '0);
      check("R11", "ret wins status", status_q, 32'h4B);
      check("R11", "ret wins target", redirect_pc, 32'h3000);

      // R10 trap and reservation in the same cycle
      resv_set = 1'b1;
      cycle(1'b1, 1'b0, 1'b0, '0, 32'd2, 32'h44);
      resv_set = 1'b0;
      check("R10", "trap beats set", resv_valid, 0);

      report();
   end

endmodule